// File: doc/BRIEF.md
# FIFO Buffer Built on a Single-Port RAM

This block is a first-in first-out buffer whose bulk storage is a single-port RAM rather than a dual-port one. Producer and consumer sit in two clock domains with no known phase or frequency relation. The RAM and its controller live in the write clock. Each RAM cycle the controller picks one operation: either it stores an incoming word, or it reads the oldest stored word out to refill a small dual-clock prefetch buffer. The read side is served only from that prefetch buffer.

The producer offers a word with `wr_valid` and the word is taken on any write-clock edge where `wr_full` is low. The consumer takes a word on any read-clock edge where both `rd_valid` and `rd_ready` are high. Total capacity is the RAM depth plus the prefetch depth. Two single-port RAMs used as alternating ping-pong banks would also give the block its two ports, but that arrangement is not built here.

Top module: `spram_fifo`

## Requirements
- R1: While either reset is held and right after it is released, `wr_full` is 0 and `rd_valid` is 0.
- R2: Words leave the read port in exactly the order they were accepted at the write port, with no word lost or repeated, whether the read clock is slower or faster than the write clock and whatever the pattern of gaps and back-pressure.
- R3: `wr_full` is 1 exactly when the words held in the RAM plus any RAM read still in flight equal the RAM depth. A word offered while `wr_full` is 1 is not stored. With the consumer stalled, exactly DEPTH + PF_DEPTH words are accepted before `wr_full` stays high.
- R4: A write has priority over a refill. In any cycle where a word is accepted, the RAM performs a write.
- R5: A refill read is issued only when no write is accepted in that cycle, the RAM holds at least one word, and the prefetch buffer has room for its own contents plus the read in flight. The prefetch buffer never receives a word while it is already full.
- R6: A RAM refill read has one cycle of latency. Its data is pushed into the prefetch buffer on the next write-clock cycle, and no push happens without such a read.
- R7: `rd_valid` is 0 when the prefetch buffer is empty. While `rd_valid` is 1 and `rd_ready` is 0, both `rd_valid` and `rd_data` stay unchanged, and `rd_data` shows the oldest word not yet read.
- R8: A single word written into an empty buffer reaches the read port without any further write. Emptiness on the read side depends only on the prefetch buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock; also clocks the RAM and the arbiter |
| wrst | input | 1 | Synchronous active-high reset for the write domain |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room; an offered word is not taken |
| rclk | input | 1 | Read-side clock, unrelated to `wclk` |
| rrst | input | 1 | Synchronous active-high reset for the read domain |
| rd_valid | output | 1 | Prefetch buffer holds a word |
| rd_ready | input | 1 | Consumer takes the word on this edge when `rd_valid` is high |
| rd_data | output | DATA_W | Oldest word not yet read |

## Verification
The assertions assume that the two resets are asserted together for several cycles of the slower clock before either one is released. They also assume that the consumer's `rd_ready` and the producer's `wr_valid`/`wr_data` change only away from their own active clock edge. The stimulus drives every input on the falling edge of its own clock and holds both resets through many cycles of both clocks. The bench checks order and completeness against a queue filled by its write driver across slow, fast and equal-ish read clocks. It also performs a stalled-consumer fill that probes the exact capacity and checks that offers made while full are dropped.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // What the arbiter does with the RAM port in one write-clock cycle
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_STORE = 2'd1,
    OP_FILL  = 2'd2
  } ram_op_e;
endpackage

// File: rtl/spf_sram.sv
module spf_sram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // One port: either a write or a registered read per cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int PF_DEPTH = 4,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int LW      = $clog2(PF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [LW-1:0] pf_level,
  output logic          wr_full,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic          pf_push,
  output logic [CW-1:0] ram_count,
  output logic          fill_busy
);
  logic [AW-1:0] wa_q, ra_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [CW-1:0] occ;
  logic          room;
  ram_op_e       op;

  assign occ     = cnt_q + CW'(busy_q);
  assign wr_full = (occ == CW'(DEPTH));
  // room for the prefetch buffer's contents plus a read already under way
  assign room    = ({1'b0, pf_level} + (LW+1)'(busy_q)) < (LW+1)'(PF_DEPTH);

  always_comb begin
    if (wr_valid && !wr_full)          op = OP_STORE;
    else if (cnt_q != '0 && room)      op = OP_FILL;
    else                               op = OP_IDLE;
  end

  assign ram_en    = (op != OP_IDLE);
  assign ram_we    = (op == OP_STORE);
  assign ram_addr  = (op == OP_STORE) ? wa_q : ra_q;
  assign pf_push   = busy_q;
  assign ram_count = cnt_q;
  assign fill_busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wa_q   <= '0;
      ra_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= (op == OP_FILL);
      if (op == OP_STORE) begin
        wa_q  <= wa_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else if (op == OP_FILL) begin
        ra_q  <= ra_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spf_xfifo.sv
module spf_xfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  output logic [LW-1:0] wlevel,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wbin, wgray, rbin, rgray;
  logic [PW:0]  rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW:0]  rbin_w, wbin_nx, rbin_nx;
  logic         pop;

  // ---- write domain ----
  assign wbin_nx = wbin + (PW+1)'(push);
  always_ff @(posedge wclk) begin
    if (push) mem[wbin[PW-1:0]] <= wdata;
  end
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end
  end
  always_comb begin
    rbin_w[PW] = rg_s2[PW];
    for (int i = PW - 1; i >= 0; i--) rbin_w[i] = rbin_w[i+1] ^ rg_s2[i];
  end
  assign wlevel = LW'(wbin - rbin_w);

  // ---- read domain ----
  assign rd_valid = (rgray != wg_s2);
  assign rd_data  = mem[rbin[PW-1:0]];
  assign pop      = rd_valid && rd_ready;
  assign rbin_nx  = rbin + (PW+1)'(pop);
  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end
  end
endmodule

// File: rtl/spram_fifo.sv
module spram_fifo #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int PF_DEPTH = 4,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int LW      = $clog2(PF_DEPTH + 1)
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rclk,
  input  logic              rrst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  logic              ram_en, ram_we, pf_push, fill_busy;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_rdata;
  logic [CW-1:0]     ram_count;
  logic [LW-1:0]     pf_level;

  spf_ctrl #(.DEPTH(DEPTH), .PF_DEPTH(PF_DEPTH)) u_ctrl (
    .clk(wclk), .rst(wrst), .wr_valid(wr_valid), .pf_level(pf_level),
    .wr_full(wr_full), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .pf_push(pf_push), .ram_count(ram_count), .fill_busy(fill_busy)
  );

  spf_sram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(wclk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(wr_data), .rdata(ram_rdata)
  );

  spf_xfifo #(.W(DATA_W), .DEPTH(PF_DEPTH)) u_pf (
    .wclk(wclk), .wrst(wrst), .push(pf_push), .wdata(ram_rdata), .wlevel(pf_level),
    .rclk(rclk), .rrst(rrst), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/spram_fifo_chk.sv
module spram_fifo_chk #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int PF_DEPTH = 4,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int LW      = $clog2(PF_DEPTH + 1)
) (
  input logic              wclk,
  input logic              wrst,
  input logic              wr_valid,
  input logic              wr_full,
  input logic              ram_en,
  input logic              ram_we,
  input logic              pf_push,
  input logic              fill_busy,
  input logic [CW-1:0]     ram_count,
  input logic [LW-1:0]     pf_level,
  input logic              rclk,
  input logic              rrst,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data
);
  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (wrst)
    ({1'b0, ram_count} + (CW+1)'(fill_busy)) <= (CW+1)'(DEPTH));
  // R4
  write_first_chk: assert property (@(posedge wclk) disable iff (wrst)
    (wr_valid && !wr_full) |-> (ram_en && ram_we));
  // R5
  fill_nonempty_chk: assert property (@(posedge wclk) disable iff (wrst)
    (ram_count == '0) |-> !(ram_en && !ram_we));
  // R5
  pf_room_chk: assert property (@(posedge wclk) disable iff (wrst)
    pf_push |-> (pf_level < LW'(PF_DEPTH)));
  // R6
  fill_latency_chk: assert property (@(posedge wclk) disable iff (wrst)
    (ram_en && !ram_we) |=> pf_push);
  // R6
  push_cause_chk: assert property (@(posedge wclk) disable iff (wrst)
    pf_push |-> $past(ram_en && !ram_we));
  // R7
  hold_stall_chk: assert property (@(posedge rclk) disable iff (rrst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind spram_fifo spram_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PF_DEPTH(PF_DEPTH)) u_chk (
  .wclk(wclk), .wrst(wrst), .wr_valid(wr_valid), .wr_full(wr_full),
  .ram_en(ram_en), .ram_we(ram_we), .pf_push(pf_push), .fill_busy(fill_busy),
  .ram_count(ram_count), .pf_level(pf_level),
  .rclk(rclk), .rrst(rrst), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/spram_fifo_tb.sv
`timescale 1ns/1ps
module spram_fifo_tb;
  localparam int DW = 16, DEPTH = 16, PFD = 4;

  logic wclk = 0, rclk = 0, wrst = 1, rrst = 1;
  logic wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_full, rd_valid;
  logic [DW-1:0] rd_data;

  real rhalf = 3.5;
  int  rmode = 0;             // 0 always ready, 1 random, 2 stalled
  int  total = 0, bad = 0;
  int  seq = 0;
  logic [DW-1:0] sb[$];

  spram_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .PF_DEPTH(PFD)) u_dut (
    .wclk(wclk), .wrst(wrst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full),
    .rclk(rclk), .rrst(rrst), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  always #2.5 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one offer per write-clock cycle; accepted words go to the scoreboard
  task automatic offer(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    wr_valid = 1'b1;
    wr_data  = d;
    acc = !wr_full;
    if (acc) sb.push_back(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic send(input int n, input bit gaps);
    bit acc;
    for (int i = 0; i < n; i++) begin
      do offer(DW'(seq * 37 + 11), acc); while (!acc);
      seq++;
      if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 4);
    end
    idle(1);
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && sb.size() != 0; i++) @(negedge wclk);
  endtask

  // monitor: scoreboard compare on the read side
  always @(negedge rclk) begin
    if (rrst) rd_ready = 1'b0;
    else begin
      case (rmode)
        0:       rd_ready = 1'b1;
        1:       rd_ready = 1'($urandom % 2);
        default: rd_ready = 1'b0;
      endcase
      if (rd_valid && rd_ready) begin
        if (sb.size() == 0) chk(0, "R2 unexpected word", int'(rd_data), -1);
        else begin
          logic [DW-1:0] e;
          e = sb.pop_front();
          chk(rd_data == e, "R2 order", int'(rd_data), int'(e));
        end
      end else if (rmode == 2 && rd_valid) begin
        // R7: a stalled word is the oldest one still owed
        if (sb.size() == 0) chk(0, "R7 valid with nothing owed", 1, 0);
        else chk(rd_data == sb[0], "R7 stalled data", int'(rd_data), int'(sb[0]));
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge wclk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    bit acc;
    int got;
    repeat (3) @(negedge wclk);
    chk(wr_full == 0, "R1 full in reset", int'(wr_full), 0);
    chk(rd_valid == 0, "R1 valid in reset", int'(rd_valid), 0);
    repeat (10) @(negedge wclk);
    wrst = 0; rrst = 0;
    @(negedge wclk);
    chk(wr_full == 0, "R1 full after reset", int'(wr_full), 0);
    chk(rd_valid == 0, "R1 valid after reset", int'(rd_valid), 0);

    // R8: one word into an empty buffer arrives with no further writes
    rmode = 0;
    send(1, 0);
    drain(40);
    chk(sb.size() == 0, "R8 single word delivered", sb.size(), 0);

    // R2: read clock a little slower, back-to-back writes
    send(40, 0);
    drain(2000);
    chk(sb.size() == 0, "R2 burst drained", sb.size(), 0);

    // R2 R5: slow read clock, random ready, random write gaps
    rhalf = 11.5; rmode = 1;
    send(60, 1);
    drain(20000);
    chk(sb.size() == 0, "R2 slow reader drained", sb.size(), 0);

    // R3 R7: consumer stalled, measure capacity, offers while full dropped
    rhalf = 3.5; rmode = 2;
    got = 0;
    for (int i = 0; i < 30; i++) begin offer(DW'(16'h8000 + i), acc); got += int'(acc); end
    idle(60);
    for (int i = 0; i < 10; i++) begin offer(DW'(16'hC000 + i), acc); got += int'(acc); end
    idle(2);
    chk(got == DEPTH + PFD, "R3 capacity", got, DEPTH + PFD);
    chk(wr_full == 1, "R3 full held", int'(wr_full), 1);
    chk(rd_valid == 1, "R7 valid while stalled", int'(rd_valid), 1);
    rmode = 0;
    drain(2000);
    chk(sb.size() == 0, "R3 stored words drained", sb.size(), 0);
    idle(20);
    chk(wr_full == 0, "R3 full released", int'(wr_full), 0);
    chk(rd_valid == 0, "R7 valid low when empty", int'(rd_valid), 0);

    // R2: read clock faster than write clock, random ready
    rhalf = 1.5; rmode = 1;
    send(50, 1);
    drain(5000);
    chk(sb.size() == 0, "R2 fast reader drained", sb.size(), 0);

    // R2: very slow reader with sustained writes
    rhalf = 17.0; rmode = 0;
    send(45, 0);
    drain(20000);
    chk(sb.size() == 0, "R2 very slow reader drained", sb.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule